// File: doc/BRIEF.md
# Virtual-Tag Hit Predictor for a Set-Associative Data Cache

This block sits in the load path of a virtually indexed, physically tagged, 4-way set-associative data cache. Each way keeps a short virtual tag next to its physical tag. A load compares the virtual tags of its set and, on a match, forwards that way's data to consumers in the same cycle. Translation still has to finish, so this forward is only a guess.

One cycle later the translated physical tag arrives. The block compares it against the physical tags of the same set and then either confirms the forwarded data or cancels it. A cancelled load is handled as a miss. If the line is actually held in another way, its data comes back through the miss path and no refill is requested. If the line is absent everywhere, a small miss tracker starts a refill only when no outstanding miss already covers that line. When the tracker is full, the load is replayed instead. A finished refill installs the line with both its tags, so later loads predict it correctly.

The data SRAM, the translation unit and the memory side lie outside the block. The data SRAM supplies all ways of the indexed set, the translator supplies the physical tag one cycle after the lookup, and memory answers refill requests by slot number.

Top module: `vtag_hit_pred`

## Requirements
- R1: In the cycle of a lookup, `pred_hit_o` is high when some valid way of the set holds the load's virtual tag. The predicted way is the lowest-numbered matching way. `pred_data_o` is that way's slice of `way_data_i` (way w occupies bits w*DATA_W and up), and is zero when there is no prediction.
- R2: In the cycle after a lookup (when `xl_ptag_i` holds that load's physical tag), exactly one of `confirm_o` or `cancel_o` is high and `val_id_o` equals the load's ID. Neither is high in a cycle that follows no lookup.
- R3: `confirm_o` is high only if the load was predicted and the predicted way is valid with a physical tag equal to the translated tag. Every other load is cancelled.
- R4: If a cancelled load's physical tag is valid in some way of its set, `mp_valid_o` returns that way's data on `mp_data_o` with `mp_id_o`, and no refill is requested.
- R5: A cancelled load whose line is absent from every way, and that no outstanding miss covers (same set and physical tag), raises `req_valid_o` when a slot is free. The request carries the lowest free slot, the set and the physical tag.
- R6: A cancelled, absent load that is covered by an outstanding miss raises `merge_o` and makes no request. This holds even when all slots are busy.
- R7: A cancelled, absent, unique load that arrives while all NMISS slots are busy raises `replay_o` and makes no request.
- R8: `refill_valid_i` for a busy slot raises `fill_valid_o` with the ID of the load that opened the slot, passes `refill_data_i` to `fill_data_o`, and raises `wr_en_o` with the line's set. The slot is free from the next cycle on. The line becomes valid with the virtual and physical tags of the opening load, so a later lookup with that virtual tag predicts a hit.
- R9: A refill writes the lowest-numbered invalid way of its set. If all ways are valid, it writes the way named by a per-set rotating pointer, which starts at way 0 and advances by one after each such replacement. `wr_way_o` reports the way written.
- R10: After reset every line is invalid, every slot is free, and all outputs that signal an event are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_valid_i | input | 1 | Load lookup this cycle |
| lk_id_i | input | ID_W | Load identifier |
| lk_index_i | input | log2(NSETS) | Set index from the virtual address |
| lk_vtag_i | input | VTAG_W | Partial virtual tag of the load |
| way_data_i | input | NWAYS*DATA_W | Data of all ways of the indexed set |
| xl_ptag_i | input | PTAG_W | Translated physical tag, one cycle after lookup |
| refill_valid_i | input | 1 | Memory returns a line |
| refill_slot_i | input | log2(NMISS) | Miss slot being answered |
| refill_data_i | input | DATA_W | Returned data |
| pred_hit_o | output | 1 | Hit predicted from the virtual tag |
| pred_data_o | output | DATA_W | Speculatively forwarded data |
| confirm_o | output | 1 | Prediction validated |
| cancel_o | output | 1 | Load reclassified as a miss |
| val_id_o | output | ID_W | Load ID for confirm or cancel |
| replay_o | output | 1 | Miss tracker full, reissue the load |
| merge_o | output | 1 | Miss joined an outstanding refill |
| req_valid_o | output | 1 | New refill request |
| req_slot_o | output | log2(NMISS) | Slot allocated to the request |
| req_index_o | output | log2(NSETS) | Set of the requested line |
| req_ptag_o | output | PTAG_W | Physical tag of the requested line |
| mp_valid_o | output | 1 | Miss-path data from a present line |
| mp_id_o | output | ID_W | Load ID for miss-path data |
| mp_data_o | output | DATA_W | Miss-path data |
| fill_valid_o | output | 1 | Refill completes this cycle |
| fill_id_o | output | ID_W | ID of the load that opened the slot |
| fill_data_o | output | DATA_W | Refill data |
| wr_en_o | output | 1 | Write the data SRAM |
| wr_index_o | output | log2(NSETS) | Set to write |
| wr_way_o | output | log2(NWAYS) | Way to write |

## Verification
On every cycle the assertions check that each lookup gets exactly one verdict with its own ID, that a confirm always follows a prediction, and that the outcomes of a cancelled load exclude one another. They also track occupancy from requests and fills, so that a request is never made into a full tracker and a replay happens only when it is full. Whether the data is right can only be shown by the bench's scenarios, because it depends on which way holds the line. The same is true of a virtual-tag alias that falls back to data from another way, the lowest-free-slot choice, and the victim rotation once a set is full.

// File: rtl/vtp_pkg.sv
package vtp_pkg;
  typedef enum logic [2:0] {
    OC_CONFIRM,
    OC_OTHER_WAY,
    OC_MERGE,
    OC_REPLAY,
    OC_REFILL
  } vtp_outcome_e;
endpackage

// File: rtl/vtp_tag_array.sv
module vtp_tag_array #(
  parameter int NWAYS  = 4,
  parameter int NSETS  = 16,
  parameter int VTAG_W = 8,
  parameter int PTAG_W = 12,
  localparam int SET_W = $clog2(NSETS),
  localparam int WAY_W = $clog2(NWAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  rd0_index_i,
  input  logic [VTAG_W-1:0] rd0_vtag_i,
  output logic [NWAYS-1:0]  vhit_o,
  input  logic [SET_W-1:0]  rd1_index_i,
  input  logic [PTAG_W-1:0] rd1_ptag_i,
  output logic [NWAYS-1:0]  phit_o,
  input  logic              wr_en_i,
  input  logic [SET_W-1:0]  wr_index_i,
  input  logic [VTAG_W-1:0] wr_vtag_i,
  input  logic [PTAG_W-1:0] wr_ptag_i,
  output logic [WAY_W-1:0]  wr_way_o
);
  logic [NWAYS-1:0]  valid_q [NSETS];
  logic [VTAG_W-1:0] vtag_q  [NSETS][NWAYS];
  logic [PTAG_W-1:0] ptag_q  [NSETS][NWAYS];
  logic [WAY_W-1:0]  rr_q    [NSETS];
  logic [NWAYS-1:0]  wr_valid;

  assign wr_valid = valid_q[wr_index_i];

  for (genvar w = 0; w < NWAYS; w++) begin : g_cmp
    assign vhit_o[w] = valid_q[rd0_index_i][w] && (vtag_q[rd0_index_i][w] == rd0_vtag_i);
    assign phit_o[w] = valid_q[rd1_index_i][w] && (ptag_q[rd1_index_i][w] == rd1_ptag_i);
  end

  // victim: lowest invalid way, else rotating pointer
  always_comb begin
    wr_way_o = rr_q[wr_index_i];
    for (int w = NWAYS - 1; w >= 0; w--)
      if (!wr_valid[w]) wr_way_o = WAY_W'(w);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NSETS; s++) begin
        valid_q[s] <= '0;
        rr_q[s]    <= '0;
      end
    end else if (wr_en_i) begin
      valid_q[wr_index_i][wr_way_o] <= 1'b1;
      vtag_q[wr_index_i][wr_way_o]  <= wr_vtag_i;
      ptag_q[wr_index_i][wr_way_o]  <= wr_ptag_i;
      if (&wr_valid)
        rr_q[wr_index_i] <= (int'(rr_q[wr_index_i]) == NWAYS - 1) ? '0 : rr_q[wr_index_i] + 1'b1;
    end
  end
endmodule

// File: rtl/vtp_miss_tracker.sv
module vtp_miss_tracker #(
  parameter int NMISS  = 4,
  parameter int SET_W  = 4,
  parameter int VTAG_W = 8,
  parameter int PTAG_W = 12,
  parameter int ID_W   = 4,
  localparam int SLOT_W = $clog2(NMISS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SET_W-1:0]  q_index_i,
  input  logic [PTAG_W-1:0] q_ptag_i,
  input  logic [VTAG_W-1:0] q_vtag_i,
  input  logic [ID_W-1:0]   q_id_i,
  input  logic              alloc_i,
  output logic              match_o,
  output logic              full_o,
  output logic [SLOT_W-1:0] free_slot_o,
  input  logic              rf_valid_i,
  input  logic [SLOT_W-1:0] rf_slot_i,
  output logic              rf_hit_o,
  output logic [SET_W-1:0]  rf_index_o,
  output logic [PTAG_W-1:0] rf_ptag_o,
  output logic [VTAG_W-1:0] rf_vtag_o,
  output logic [ID_W-1:0]   rf_id_o
);
  logic [NMISS-1:0]  valid_q;
  logic [SET_W-1:0]  idx_q  [NMISS];
  logic [PTAG_W-1:0] ptag_q [NMISS];
  logic [VTAG_W-1:0] vtag_q [NMISS];
  logic [ID_W-1:0]   id_q   [NMISS];
  logic [NMISS-1:0]  hit_vec;

  for (genvar g = 0; g < NMISS; g++) begin : g_match
    assign hit_vec[g] = valid_q[g] && (idx_q[g] == q_index_i) && (ptag_q[g] == q_ptag_i);
  end

  assign match_o = |hit_vec;
  assign full_o  = &valid_q;

  always_comb begin
    free_slot_o = '0;
    for (int i = NMISS - 1; i >= 0; i--)
      if (!valid_q[i]) free_slot_o = SLOT_W'(i);
  end

  assign rf_hit_o   = rf_valid_i && valid_q[rf_slot_i];
  assign rf_index_o = idx_q[rf_slot_i];
  assign rf_ptag_o  = ptag_q[rf_slot_i];
  assign rf_vtag_o  = vtag_q[rf_slot_i];
  assign rf_id_o    = id_q[rf_slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else begin
      if (rf_hit_o) valid_q[rf_slot_i] <= 1'b0;
      if (alloc_i) begin
        valid_q[free_slot_o] <= 1'b1;
        idx_q[free_slot_o]   <= q_index_i;
        ptag_q[free_slot_o]  <= q_ptag_i;
        vtag_q[free_slot_o]  <= q_vtag_i;
        id_q[free_slot_o]    <= q_id_i;
      end
    end
  end
endmodule

// File: rtl/vtag_hit_pred.sv
module vtag_hit_pred
  import vtp_pkg::*;
#(
  parameter int NWAYS  = 4,
  parameter int NSETS  = 16,
  parameter int VTAG_W = 8,
  parameter int PTAG_W = 12,
  parameter int DATA_W = 32,
  parameter int NMISS  = 4,
  parameter int ID_W   = 4
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      lk_valid_i,
  input  logic [ID_W-1:0]           lk_id_i,
  input  logic [$clog2(NSETS)-1:0]  lk_index_i,
  input  logic [VTAG_W-1:0]         lk_vtag_i,
  input  logic [NWAYS*DATA_W-1:0]   way_data_i,
  input  logic [PTAG_W-1:0]         xl_ptag_i,
  input  logic                      refill_valid_i,
  input  logic [$clog2(NMISS)-1:0]  refill_slot_i,
  input  logic [DATA_W-1:0]         refill_data_i,
  output logic                      pred_hit_o,
  output logic [DATA_W-1:0]         pred_data_o,
  output logic                      confirm_o,
  output logic                      cancel_o,
  output logic [ID_W-1:0]           val_id_o,
  output logic                      replay_o,
  output logic                      merge_o,
  output logic                      req_valid_o,
  output logic [$clog2(NMISS)-1:0]  req_slot_o,
  output logic [$clog2(NSETS)-1:0]  req_index_o,
  output logic [PTAG_W-1:0]         req_ptag_o,
  output logic                      mp_valid_o,
  output logic [ID_W-1:0]           mp_id_o,
  output logic [DATA_W-1:0]         mp_data_o,
  output logic                      fill_valid_o,
  output logic [ID_W-1:0]           fill_id_o,
  output logic [DATA_W-1:0]         fill_data_o,
  output logic                      wr_en_o,
  output logic [$clog2(NSETS)-1:0]  wr_index_o,
  output logic [$clog2(NWAYS)-1:0]  wr_way_o
);
  localparam int SET_W  = $clog2(NSETS);
  localparam int WAY_W  = $clog2(NWAYS);
  localparam int SLOT_W = $clog2(NMISS);

  logic [NWAYS-1:0] vhit, phit;
  logic [WAY_W-1:0] pred_way, phit_way;

  // stage 1 (validation) state
  logic                    s1_valid_q, s1_pred_q;
  logic [ID_W-1:0]         s1_id_q;
  logic [SET_W-1:0]        s1_index_q;
  logic [VTAG_W-1:0]       s1_vtag_q;
  logic [WAY_W-1:0]        s1_way_q;
  logic [NWAYS*DATA_W-1:0] s1_data_q;

  logic              trk_match, trk_full, rf_hit;
  logic [SLOT_W-1:0] trk_free;
  logic [SET_W-1:0]  rf_index;
  logic [PTAG_W-1:0] rf_ptag;
  logic [VTAG_W-1:0] rf_vtag;
  logic [ID_W-1:0]   rf_id;
  vtp_outcome_e      outcome;

  vtp_tag_array #(
    .NWAYS(NWAYS), .NSETS(NSETS), .VTAG_W(VTAG_W), .PTAG_W(PTAG_W)
  ) u_tags (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .rd0_index_i(lk_index_i), .rd0_vtag_i(lk_vtag_i), .vhit_o(vhit),
    .rd1_index_i(s1_index_q), .rd1_ptag_i(xl_ptag_i), .phit_o(phit),
    .wr_en_i(rf_hit), .wr_index_i(rf_index), .wr_vtag_i(rf_vtag),
    .wr_ptag_i(rf_ptag), .wr_way_o(wr_way_o)
  );

  vtp_miss_tracker #(
    .NMISS(NMISS), .SET_W(SET_W), .VTAG_W(VTAG_W), .PTAG_W(PTAG_W), .ID_W(ID_W)
  ) u_trk (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .q_index_i(s1_index_q), .q_ptag_i(xl_ptag_i), .q_vtag_i(s1_vtag_q),
    .q_id_i(s1_id_q), .alloc_i(req_valid_o),
    .match_o(trk_match), .full_o(trk_full), .free_slot_o(trk_free),
    .rf_valid_i(refill_valid_i), .rf_slot_i(refill_slot_i),
    .rf_hit_o(rf_hit), .rf_index_o(rf_index), .rf_ptag_o(rf_ptag),
    .rf_vtag_o(rf_vtag), .rf_id_o(rf_id)
  );

  always_comb begin
    pred_way = '0;
    phit_way = '0;
    for (int w = NWAYS - 1; w >= 0; w--) begin
      if (vhit[w]) pred_way = WAY_W'(w);
      if (phit[w]) phit_way = WAY_W'(w);
    end
  end

  assign pred_hit_o  = lk_valid_i && (|vhit);
  assign pred_data_o = pred_hit_o ? way_data_i[int'(pred_way)*DATA_W +: DATA_W] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid_q <= 1'b0;
      s1_pred_q  <= 1'b0;
      s1_id_q    <= '0;
      s1_index_q <= '0;
      s1_vtag_q  <= '0;
      s1_way_q   <= '0;
      s1_data_q  <= '0;
    end else begin
      s1_valid_q <= lk_valid_i;
      if (lk_valid_i) begin
        s1_pred_q  <= |vhit;
        s1_id_q    <= lk_id_i;
        s1_index_q <= lk_index_i;
        s1_vtag_q  <= lk_vtag_i;
        s1_way_q   <= pred_way;
        s1_data_q  <= way_data_i;
      end
    end
  end

  always_comb begin
    if (s1_pred_q && phit[s1_way_q]) outcome = OC_CONFIRM;
    else if (|phit)                  outcome = OC_OTHER_WAY;
    else if (trk_match)              outcome = OC_MERGE;
    else if (trk_full)               outcome = OC_REPLAY;
    else                             outcome = OC_REFILL;
  end

  assign confirm_o   = s1_valid_q && (outcome == OC_CONFIRM);
  assign cancel_o    = s1_valid_q && (outcome != OC_CONFIRM);
  assign val_id_o    = s1_id_q;
  assign mp_valid_o  = s1_valid_q && (outcome == OC_OTHER_WAY);
  assign mp_id_o     = s1_id_q;
  assign mp_data_o   = s1_data_q[int'(phit_way)*DATA_W +: DATA_W];
  assign merge_o     = s1_valid_q && (outcome == OC_MERGE);
  assign replay_o    = s1_valid_q && (outcome == OC_REPLAY);
  assign req_valid_o = s1_valid_q && (outcome == OC_REFILL);
  assign req_slot_o  = trk_free;
  assign req_index_o = s1_index_q;
  assign req_ptag_o  = xl_ptag_i;

  assign fill_valid_o = rf_hit;
  assign fill_id_o    = rf_id;
  assign fill_data_o  = refill_data_i;
  assign wr_en_o      = rf_hit;
  assign wr_index_o   = rf_index;
endmodule

// File: rtl/vtp_checker.sv
module vtp_checker #(
  parameter int NMISS = 4,
  parameter int ID_W  = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            lk_valid_i,
  input logic [ID_W-1:0] lk_id_i,
  input logic            pred_hit_o,
  input logic            confirm_o,
  input logic            cancel_o,
  input logic [ID_W-1:0] val_id_o,
  input logic            replay_o,
  input logic            merge_o,
  input logic            req_valid_o,
  input logic            mp_valid_o,
  input logic            fill_valid_o
);
  localparam int CNT_W = $clog2(NMISS + 1) + 1;
  logic [CNT_W-1:0] busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= '0;
    else         busy_q <= busy_q + CNT_W'(req_valid_o) - CNT_W'(fill_valid_o);
  end

  assert_one_verdict_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(lk_valid_i) == (confirm_o || cancel_o)) && !(confirm_o && cancel_o));
  assert_verdict_id_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (confirm_o || cancel_o) |-> (val_id_o == $past(lk_id_i)));
  assert_confirm_pred_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    confirm_o |-> $past(pred_hit_o));
  assert_present_no_req_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mp_valid_o |-> (cancel_o && !req_valid_o && !merge_o && !replay_o));
  assert_req_room_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (busy_q < CNT_W'(NMISS)));
  assert_merge_excl_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    merge_o |-> (cancel_o && !req_valid_o && !replay_o));
  assert_replay_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_o |-> (busy_q == CNT_W'(NMISS) && !req_valid_o));
  assert_fill_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_valid_o |-> (busy_q != '0));
endmodule

bind vtag_hit_pred vtp_checker #(.NMISS(NMISS), .ID_W(ID_W)) u_vtp_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .lk_valid_i(lk_valid_i), .lk_id_i(lk_id_i),
  .pred_hit_o(pred_hit_o), .confirm_o(confirm_o), .cancel_o(cancel_o),
  .val_id_o(val_id_o), .replay_o(replay_o), .merge_o(merge_o),
  .req_valid_o(req_valid_o), .mp_valid_o(mp_valid_o), .fill_valid_o(fill_valid_o)
);

// File: tb/vtag_hit_pred_test.sv
module vtag_hit_pred_test;
  localparam int NW = 4, NS = 16, VW = 8, PW = 12, DW = 32, NM = 4, IW = 4;

  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic          lk_valid = 0, refill_valid = 0;
  logic [IW-1:0] lk_id = 0;
  logic [3:0]    lk_index = 0;
  logic [VW-1:0] lk_vtag = 0;
  logic [NW*DW-1:0] way_data = 0;
  logic [PW-1:0] xl_ptag = 0;
  logic [1:0]    refill_slot = 0;
  logic [DW-1:0] refill_data = 0;

  logic pred_hit, confirm, cancel, replay, merge, req_valid, mp_valid, fill_valid, wr_en;
  logic [DW-1:0] pred_data, mp_data, fill_data;
  logic [IW-1:0] val_id, mp_id, fill_id;
  logic [1:0] req_slot, wr_way;
  logic [3:0] req_index, wr_index;
  logic [PW-1:0] req_ptag;

  vtag_hit_pred uut (
    .clk_i(clk), .rst_ni(rst_n), .lk_valid_i(lk_valid), .lk_id_i(lk_id),
    .lk_index_i(lk_index), .lk_vtag_i(lk_vtag), .way_data_i(way_data),
    .xl_ptag_i(xl_ptag), .refill_valid_i(refill_valid), .refill_slot_i(refill_slot),
    .refill_data_i(refill_data), .pred_hit_o(pred_hit), .pred_data_o(pred_data),
    .confirm_o(confirm), .cancel_o(cancel), .val_id_o(val_id), .replay_o(replay),
    .merge_o(merge), .req_valid_o(req_valid), .req_slot_o(req_slot),
    .req_index_o(req_index), .req_ptag_o(req_ptag), .mp_valid_o(mp_valid),
    .mp_id_o(mp_id), .mp_data_o(mp_data), .fill_valid_o(fill_valid),
    .fill_id_o(fill_id), .fill_data_o(fill_data), .wr_en_o(wr_en),
    .wr_index_o(wr_index), .wr_way_o(wr_way)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model
  bit          m_val [NS][NW];
  logic [VW-1:0] m_vt [NS][NW];
  logic [PW-1:0] m_pt [NS][NW];
  logic [DW-1:0] m_dat [NS][NW];
  int          m_rr [NS];
  bit          t_val [NM];
  logic [3:0]  t_set [NM];
  logic [PW-1:0] t_pt [NM];
  logic [VW-1:0] t_vt [NM];
  logic [IW-1:0] t_id [NM];

  typedef struct {
    logic conf, canc, mp, mrg, rpl, req;
    logic [1:0] slot;
    logic [IW-1:0] id;
    logic [DW-1:0] data;
  } exp_t;
  exp_t expq[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [IW-1:0] id, input logic [3:0] set,
                         input logic [VW-1:0] vt, input logic [PW-1:0] pt);
    int pw, hw, fs;
    bit tm, full;
    exp_t e;
    @(negedge clk);
    lk_valid = 1; lk_id = id; lk_index = set; lk_vtag = vt;
    for (int w = 0; w < NW; w++) way_data[w*DW +: DW] = m_dat[set][w];
    pw = -1;
    for (int w = NW - 1; w >= 0; w--) if (m_val[set][w] && m_vt[set][w] == vt) pw = w;
    #1;
    chk(pred_hit == (pw >= 0), "R1", "pred_hit", 64'(pred_hit), 64'(pw >= 0));
    chk(pred_data == ((pw >= 0) ? m_dat[set][pw] : '0), "R1", "pred_data", 64'(pred_data),
        64'((pw >= 0) ? m_dat[set][pw] : '0));
    @(negedge clk);
    lk_valid = 0; xl_ptag = pt;
    hw = -1;
    for (int w = NW - 1; w >= 0; w--) if (m_val[set][w] && m_pt[set][w] == pt) hw = w;
    tm = 0; full = 1; fs = -1;
    for (int i = NM - 1; i >= 0; i--) begin
      if (t_val[i] && t_set[i] == set && t_pt[i] == pt) tm = 1;
      if (!t_val[i]) begin full = 0; fs = i; end
    end
    e = '{conf:0, canc:1, mp:0, mrg:0, rpl:0, req:0, slot:0, id:id, data:0};
    if (pw >= 0 && hw == pw) begin e.conf = 1; e.canc = 0; end
    else if (hw >= 0) begin e.mp = 1; e.data = m_dat[set][hw]; end
    else if (tm) e.mrg = 1;
    else if (full) e.rpl = 1;
    else begin
      e.req = 1; e.slot = 2'(fs);
      t_val[fs] = 1; t_set[fs] = set; t_pt[fs] = pt; t_vt[fs] = vt; t_id[fs] = id;
    end
    expq.push_back(e);
  endtask

  task automatic do_fill(input int slot, input logic [DW-1:0] d);
    int vw, s;
    bit allv;
    @(negedge clk);
    refill_valid = 1; refill_slot = 2'(slot); refill_data = d;
    s = t_set[slot];
    vw = -1; allv = 1;
    for (int w = NW - 1; w >= 0; w--) if (!m_val[s][w]) begin vw = w; allv = 0; end
    if (allv) vw = m_rr[s];
    #1;
    chk(fill_valid && wr_en, "R8", "fill_valid", 64'(fill_valid), 1);
    chk(fill_id == t_id[slot], "R8", "fill_id", 64'(fill_id), 64'(t_id[slot]));
    chk(fill_data == d, "R8", "fill_data", 64'(fill_data), 64'(d));
    chk(wr_index == 4'(s), "R8", "wr_index", 64'(wr_index), 64'(s));
    chk(wr_way == 2'(vw), "R9", "wr_way", 64'(wr_way), 64'(vw));
    m_val[s][vw] = 1; m_vt[s][vw] = t_vt[slot]; m_pt[s][vw] = t_pt[slot]; m_dat[s][vw] = d;
    if (allv) m_rr[s] = (m_rr[s] + 1) % NW;
    t_val[slot] = 0;
    @(negedge clk);
    refill_valid = 0;
  endtask

  // monitor: pops expected verdicts
  initial begin
    exp_t e;
    forever begin
      @(negedge clk); #2;
      if (rst_n && (confirm || cancel)) begin
        if (expq.size() == 0) chk(0, "R2", "unexpected verdict", 64'(val_id), 0);
        else begin
          e = expq.pop_front();
          chk(confirm == e.conf && cancel == e.canc, "R3", "confirm/cancel",
              64'({confirm, cancel}), 64'({e.conf, e.canc}));
          chk(val_id == e.id, "R2", "val_id", 64'(val_id), 64'(e.id));
          chk(mp_valid == e.mp, "R4", "mp_valid", 64'(mp_valid), 64'(e.mp));
          if (e.mp) chk(mp_data == e.data && mp_id == e.id, "R4", "mp_data", 64'(mp_data), 64'(e.data));
          chk(merge == e.mrg, "R6", "merge", 64'(merge), 64'(e.mrg));
          chk(replay == e.rpl, "R7", "replay", 64'(replay), 64'(e.rpl));
          chk(req_valid == e.req, "R5", "req_valid", 64'(req_valid), 64'(e.req));
          if (e.req) chk(req_slot == e.slot && req_index == lk_index && req_ptag == xl_ptag,
                         "R5", "req fields", 64'({req_slot, req_index, req_ptag}),
                         64'({e.slot, lk_index, xl_ptag}));
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", "timeout", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++) begin
      m_rr[s] = 0;
      for (int w = 0; w < NW; w++) begin
        m_val[s][w] = 0; m_dat[s][w] = 32'hD000_0000 | (s << 8) | w;
      end
    end
    for (int i = 0; i < NM; i++) t_val[i] = 0;
    repeat (3) @(negedge clk);
    #1;
    chk(!pred_hit && !confirm && !cancel && !req_valid && !fill_valid && !replay && !merge,
        "R10", "idle after reset", 64'({pred_hit, confirm, cancel, req_valid, fill_valid}), 0);
    rst_n = 1;
    do_load(1, 3, 8'h11, 12'h111);          // R5 miss, slot 0
    do_fill(0, 32'hA000_0001);              // R8 installs way 0
    do_load(2, 3, 8'h11, 12'h111);          // R1 R3 confirm
    do_load(3, 3, 8'h11, 12'h222);          // R3 alias cancel, refill
    do_load(4, 3, 8'h33, 12'h222);          // R6 merge
    do_fill(0, 32'hB000_0002);              // R9 lowest invalid way 1
    do_load(5, 3, 8'h11, 12'h222);          // R4 line in other way
    do_load(6, 5, 8'h51, 12'h501);
    do_load(7, 5, 8'h52, 12'h502);
    do_load(8, 5, 8'h53, 12'h503);
    do_load(9, 5, 8'h54, 12'h504);          // tracker now full
    do_load(10, 7, 8'h70, 12'h700);         // R7 replay
    do_load(11, 5, 8'h55, 12'h502);         // R6 merge while full
    do_fill(2, 32'hC000_0503);
    do_load(12, 7, 8'h70, 12'h700);         // R5 lowest free slot 2
    do_fill(0, 32'hC000_0501);
    do_fill(1, 32'hC000_0502);
    do_fill(3, 32'hC000_0504);              // set 5 full
    do_fill(2, 32'hE000_0700);
    do_load(13, 5, 8'h60, 12'h5AA);
    do_fill(0, 32'hF000_05AA);              // R9 rotate to way 0
    do_load(14, 5, 8'h53, 12'h503);         // evicted line misses
    do_fill(0, 32'hF100_0503);              // R9 rotate to way 1
    do_load(15, 5, 8'h60, 12'h5AA);         // R8 vtag retrained, confirm
    do_load(1, 7, 8'h70, 12'h700);          // R1 R3 confirm other set
    repeat (3) @(negedge clk);
    chk(expq.size() == 0, "R2", "verdicts outstanding", 64'(expq.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule